// File: doc/BRIEF.md
# Compressed-Audio Burst Preamble Detector

This block watches the sub-frame words recovered from a digital-audio receiver and decides whether the stream carries plain PCM samples or bursts of compressed data. A compressed burst opens with two fixed sync words. A burst-info word and a length-code word follow them. When all four arrive back to back, the block records the two header words, raises a non-PCM flag and requests an interrupt.

Once the flag is up, the block counts frames. One frame is one left-channel word. If a full repetition window passes with no new preamble, the stream is taken to be PCM again and matching starts over. Any change of the flag requests an interrupt. The request stays up until the host acknowledges it after reading status. Decoding of the payload is left to downstream logic.

Top module: `bpd_burst_detector`

## Requirements
- R1: After reset the flag is 0, the interrupt is 0, and the captured burst-info and length words are 0.
- R2: A preamble is four consecutive valid words. Their upper 16 bits (bits 23:8) are 0xF872, then 0x4E1F, then any burst-info value, then any length-code value. The flag is 1 from the clock edge that accepts the fourth word. Cycles with the valid strobe low between these words do not break the sequence.
- R3: Bits 7:0 of each word are stuffing and never affect matching or captured values.
- R4: If a word in the second slot is not 0x4E1F, the match restarts. If that word is 0xF872, it counts as a new first sync word. Words after a broken match are not captured.
- R5: The burst-info and length outputs load only on a complete preamble. At all other times they hold their values.
- R6: While the flag is 1, each valid word with the left indicator high counts one frame. Right-channel words do not count. The TIMEOUT_FRAMES-th counted frame after the last complete preamble (default 4096) clears the flag.
- R7: A complete preamble restarts the frame count at zero, including while the flag is already 1.
- R8: The interrupt is set when the flag rises or falls, and it stays high until the acknowledge input is high at a clock edge. A set in the same cycle wins over the acknowledge. A repeated preamble while the flag is already 1 does not set the interrupt.
- R9: A cycle with the valid strobe low changes no output, whatever the word and left inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_valid_i | input | 1 | A sub-frame word is present this cycle |
| left_i | input | 1 | The present word belongs to the left channel |
| word_i | input | 24 | Received sub-frame word |
| irq_ack_i | input | 1 | Acknowledge; clears the interrupt after a status read |
| non_pcm_o | output | 1 | 1 while the stream is classified as compressed data |
| burst_info_o | output | 16 | Burst-info word from the last complete preamble |
| length_o | output | 16 | Length-code word from the last complete preamble |
| irq_o | output | 1 | Held interrupt request on a classification change |

## Verification
A matcher stuck in the wrong slot shows up either as a missing flag rise or as header words captured one word late. This is visible at the edge that accepts the fourth preamble word. A frame counter that counts right-channel words, or that is not restarted by a preamble, moves the fall of the flag away from the exact TIMEOUT_FRAMES-th left word. The bench therefore checks the flag one frame before and one frame at the boundary. Faults in the interrupt logic show as a missing request on either edge of the flag, or as a request lost when the acknowledge coincides with a new event.

// File: rtl/bpd_pkg.sv
package bpd_pkg;
  localparam int unsigned WORD_W = 24;
  localparam int unsigned PRE_W  = 16;
  localparam logic [PRE_W-1:0] SYNC_A = 16'hF872;
  localparam logic [PRE_W-1:0] SYNC_B = 16'h4E1F;

  typedef enum logic [1:0] {
    SLOT_SYNC_A = 2'd0,
    SLOT_SYNC_B = 2'd1,
    SLOT_INFO   = 2'd2,
    SLOT_LEN    = 2'd3
  } slot_e;
endpackage

// File: rtl/bpd_sync_match.sv
module bpd_sync_match
  import bpd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [PRE_W-1:0]  hi_i,
  output logic              hit_o,
  output logic [PRE_W-1:0]  info_o,
  output logic [PRE_W-1:0]  len_o
);
  slot_e             slot_q, slot_d;
  logic [PRE_W-1:0]  info_q;

  always_comb begin
    slot_d = slot_q;
    if (valid_i) begin
      unique case (slot_q)
        SLOT_SYNC_A: slot_d = (hi_i == SYNC_A) ? SLOT_SYNC_B : SLOT_SYNC_A;
        SLOT_SYNC_B: begin
          if (hi_i == SYNC_B)      slot_d = SLOT_INFO;
          else if (hi_i == SYNC_A) slot_d = SLOT_SYNC_B;
          else                     slot_d = SLOT_SYNC_A;
        end
        SLOT_INFO:   slot_d = SLOT_LEN;
        SLOT_LEN:    slot_d = SLOT_SYNC_A;
        default:     slot_d = SLOT_SYNC_A;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= SLOT_SYNC_A;
      info_q <= '0;
    end else begin
      slot_q <= slot_d;
      if (valid_i && slot_q == SLOT_INFO) info_q <= hi_i;
    end
  end

  assign hit_o  = valid_i && (slot_q == SLOT_LEN);
  assign info_o = info_q;
  assign len_o  = hi_i;
endmodule

// File: rtl/bpd_frame_timer.sv
module bpd_frame_timer #(
  parameter int unsigned TIMEOUT_FRAMES = 4096,
  localparam int unsigned CW = $clog2(TIMEOUT_FRAMES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic          restart_i,
  output logic          expire_o,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;

  assign expire_o = run_i && tick_i && !restart_i &&
                    (cnt_q == CW'(TIMEOUT_FRAMES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (restart_i || !run_i)  cnt_q <= '0;
    else if (expire_o)             cnt_q <= '0;
    else if (tick_i)               cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/bpd_burst_detector.sv
module bpd_burst_detector
  import bpd_pkg::*;
#(
  parameter int unsigned TIMEOUT_FRAMES = 4096,
  localparam int unsigned CW = $clog2(TIMEOUT_FRAMES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_valid_i,
  input  logic              left_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              irq_ack_i,
  output logic              non_pcm_o,
  output logic [PRE_W-1:0]  burst_info_o,
  output logic [PRE_W-1:0]  length_o,
  output logic              irq_o
);
  logic             hit, expire;
  logic [PRE_W-1:0] m_info, m_len;
  logic [CW-1:0]    frame_cnt;
  logic             flag_q, irq_q;
  logic [PRE_W-1:0] info_q, len_q;

  bpd_sync_match u_match (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (word_valid_i),
    .hi_i    (word_i[WORD_W-1 -: PRE_W]),
    .hit_o   (hit),
    .info_o  (m_info),
    .len_o   (m_len)
  );

  bpd_frame_timer #(.TIMEOUT_FRAMES(TIMEOUT_FRAMES)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (flag_q),
    .tick_i    (word_valid_i && left_i),
    .restart_i (hit),
    .expire_o  (expire),
    .cnt_o     (frame_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
      info_q <= '0;
      len_q  <= '0;
    end else begin
      if (hit) begin
        flag_q <= 1'b1;
        info_q <= m_info;
        len_q  <= m_len;
      end else if (expire) begin
        flag_q <= 1'b0;
      end
      // event set outranks acknowledge
      if ((hit && !flag_q) || expire) irq_q <= 1'b1;
      else if (irq_ack_i)             irq_q <= 1'b0;
    end
  end

  assign non_pcm_o    = flag_q;
  assign irq_o        = irq_q;
  assign burst_info_o = info_q;
  assign length_o     = len_q;
endmodule

// File: rtl/bpd_checker.sv
module bpd_checker #(
  parameter int unsigned TIMEOUT_FRAMES = 4096,
  localparam int unsigned CW = $clog2(TIMEOUT_FRAMES + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          word_valid_i,
  input logic          irq_ack_i,
  input logic          non_pcm_o,
  input logic [15:0]   burst_info_o,
  input logic [15:0]   length_o,
  input logic          irq_o,
  input logic [CW-1:0] frame_cnt
);
  a_r8_irq_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(non_pcm_o) |-> irq_o);
  a_r8_irq_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(non_pcm_o) |-> irq_o);
  a_r8_irq_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_ack_i) |=> irq_o);
  a_r9_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_valid_i |=> ($stable(non_pcm_o) && $stable(burst_info_o) && $stable(length_o)));
  a_r5_hold_while_pcm_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_valid_i |=> $stable(irq_o) || !irq_o);
  a_r6_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_cnt < CW'(TIMEOUT_FRAMES));
  a_r6_cnt_idle_pcm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !non_pcm_o |=> frame_cnt == '0);
endmodule

bind bpd_burst_detector bpd_checker #(.TIMEOUT_FRAMES(TIMEOUT_FRAMES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .word_valid_i (word_valid_i),
  .irq_ack_i    (irq_ack_i),
  .non_pcm_o    (non_pcm_o),
  .burst_info_o (burst_info_o),
  .length_o     (length_o),
  .irq_o        (irq_o),
  .frame_cnt    (frame_cnt)
);

// File: tb/tb_bpd_burst_detector.sv
module tb_bpd_burst_detector;
  localparam int TO = 4096;
  localparam int NV = 14;
  // {left, word[23:0], flag, irq, info[15:0], len[15:0]}
  localparam logic [58:0] VEC [NV] = '{
    {1'b1, 24'hF87200, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {1'b0, 24'h4E1F00, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {1'b1, 24'h000AAB, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {1'b0, 24'h1234CD, 1'b1, 1'b1, 16'h000A, 16'h1234},
    {1'b1, 24'hF87200, 1'b1, 1'b1, 16'h000A, 16'h1234},
    {1'b0, 24'hF87211, 1'b1, 1'b1, 16'h000A, 16'h1234},
    {1'b1, 24'h4E1F00, 1'b1, 1'b1, 16'h000A, 16'h1234},
    {1'b0, 24'h001500, 1'b1, 1'b1, 16'h000A, 16'h1234},
    {1'b1, 24'h080000, 1'b1, 1'b1, 16'h0015, 16'h0800},
    {1'b1, 24'hF87200, 1'b1, 1'b1, 16'h0015, 16'h0800},
    {1'b0, 24'h123400, 1'b1, 1'b1, 16'h0015, 16'h0800},
    {1'b1, 24'h4E1F00, 1'b1, 1'b1, 16'h0015, 16'h0800},
    {1'b0, 24'h000700, 1'b1, 1'b1, 16'h0015, 16'h0800},
    {1'b1, 24'h000900, 1'b1, 1'b1, 16'h0015, 16'h0800}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0;
  logic        lft = 1'b0;
  logic [23:0] wd = '0;
  logic        ack = 1'b0;
  logic        flag, irq;
  logic [15:0] info, len;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bpd_burst_detector #(.TIMEOUT_FRAMES(TO)) dut (
    .clk_i(clk), .rst_ni(rst_n), .word_valid_i(vld), .left_i(lft),
    .word_i(wd), .irq_ack_i(ack), .non_pcm_o(flag),
    .burst_info_o(info), .length_o(len), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic state_chk(input string req, input logic f, input logic i,
                           input logic [15:0] bi, input logic [15:0] bl);
    chk(req, {flag, irq, info, len}, {f, i, bi, bl});
  endtask

  // called at a negedge; returns at the following negedge
  task automatic send(input logic l, input logic [23:0] w);
    vld = 1'b1; lft = l; wd = w;
    @(negedge clk);
    vld = 1'b0;
  endtask

  task automatic frames(input int n);
    for (int k = 0; k < n; k++) begin
      send(1'b1, 24'h0);
      send(1'b0, 24'h0);
    end
  endtask

  task automatic preamble(input logic [15:0] bi, input logic [15:0] bl);
    send(1'b1, 24'hF87200);
    send(1'b0, 24'h4E1F00);
    send(1'b1, {bi, 8'h00});
    send(1'b0, {bl, 8'h00});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    state_chk("R1 reset", 1'b0, 1'b0, 16'h0, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5 table walk
    for (int v = 0; v < NV; v++) begin
      send(VEC[v][58], VEC[v][57:34]);
      state_chk($sformatf("R2/R3/R4/R5 vec %0d", v), VEC[v][33], VEC[v][32],
                VEC[v][31:16], VEC[v][15:0]);
    end

    // R8 acknowledge clears the request
    ack = 1'b1; @(negedge clk); ack = 1'b0;
    chk("R8 ack clears", {33'b0, irq}, 34'b0);

    // R9 idle cycles with a preamble on the bus change nothing
    lft = 1'b1; wd = 24'hF87200; @(negedge clk);
    wd = 24'h4E1F00; @(negedge clk);
    wd = 24'hAAAA00; @(negedge clk);
    wd = 24'hBBBB00; @(negedge clk);
    state_chk("R9 idle ignored", 1'b1, 1'b0, 16'h0015, 16'h0800);

    // R2 gaps inside the preamble, R8 no request on repeat
    send(1'b1, 24'hF87200); @(negedge clk);
    send(1'b0, 24'h4E1F00); @(negedge clk); @(negedge clk);
    send(1'b1, 24'h2222FF); @(negedge clk);
    send(1'b0, 24'h3333EE);
    state_chk("R2 gaps / R8 repeat no irq", 1'b1, 1'b0, 16'h2222, 16'h3333);

    // R7 restart of the frame count
    frames(4000);
    chk("R6 still non-pcm", {33'b0, flag}, 34'b1);
    preamble(16'h0044, 16'h0055);
    frames(TO - 1);
    state_chk("R7 count restarted", 1'b1, 1'b0, 16'h0044, 16'h0055);
    // R6 right-channel words do not count
    send(1'b0, 24'h0); send(1'b0, 24'h0);
    chk("R6 right words ignored", {33'b0, flag}, 34'b1);
    // R6 timeout on the TO-th left word, R8 set wins over ack
    ack = 1'b1;
    send(1'b1, 24'h0);
    ack = 1'b0;
    state_chk("R6 timeout / R8 set over ack", 1'b0, 1'b1, 16'h0044, 16'h0055);

    ack = 1'b1; @(negedge clk); ack = 1'b0;
    chk("R8 ack after fall", {33'b0, irq}, 34'b0);

    // R4 after PCM fallback, broken preamble captures nothing
    send(1'b1, 24'hF87200);
    send(1'b0, 24'h777700);
    send(1'b1, 24'h4E1F00);
    send(1'b0, 24'h888800);
    state_chk("R4 broken match", 1'b0, 1'b0, 16'h0044, 16'h0055);

    // R1 asynchronous reset mid-stream
    preamble(16'h0101, 16'h0202);
    state_chk("R2 relock", 1'b1, 1'b1, 16'h0101, 16'h0202);
    rst_n = 1'b0; #2;
    state_chk("R1 async reset", 1'b0, 1'b0, 16'h0, 16'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule